// File: doc/BRIEF.md
# Block-Mode DMA Transfer Sequencer

This block is a single DMA channel that works in block mode. Software loads a configuration word holding a per-request unit count (the block size, 1 to 256) and a count of blocks still to run, together with a source address, a destination address, a byte/word unit size, an address step mode for each side and a bus-yield enable. Each accepted transfer request then moves one whole block. Each unit takes a read cycle at the source address followed by a write cycle at the destination address, over a simple bus-master port with a request/grant handshake.

Both address counters step after every unit. They keep their values from one block to the next and are reloaded only by a new configuration. A higher-priority request input stops a new block from being accepted and is reported as held while a block runs. A bus-yield mode lets another master take the bus between units. An abort input ends the current block at once. When the last block completes, the channel disables itself and raises a completion interrupt.

The state machine has five states. IDLE: waits for a request. WAITGNT: the bus is requested and the grant is awaited. READ: source cycle. WRITE: destination cycle. YIELD: the bus is handed to another master.

Transitions:
- IDLE to WAITGNT on an accepted request.
- WAITGNT to READ on grant.
- READ to WRITE always.
- WRITE to IDLE after the final unit.
- WRITE to YIELD when yield is enabled and another master requests the bus.
- WRITE to READ otherwise.
- YIELD to WAITGNT when the other master drops its request.
- Any active state to IDLE on abort.

Top module: `dma_blk_seq`

## Requirements
- R1: A `cfg_load` pulse in IDLE latches the configuration. It sets `chan_en` to 1, clears `irq` and loads `blocks_left` from `cfg_szcnt[15:0]`. A pulse while a block is active has no effect.
- R2: In IDLE with `chan_en`=1, `xfer_req`=1 and `hi_pri_req`=0, the request is accepted. `ack` pulses for exactly one cycle, in the cycle after acceptance, and pulses once per block.
- R3: A block moves N units, where N = `cfg_szcnt[23:16]` and a value of 0 means 256. Each unit writes to the destination the data read from the source.
- R4: Address step mode 2'b01 increments, 2'b10 decrements and 2'b00/2'b11 hold. The step is 1 for byte units (`cfg_word`=0) and 2 for word units.
- R5: Source and destination addresses carry on from one block to the next and are never restored.
- R6: `blk_end` is high only during the write cycle of the final unit of a block.
- R7: `bus_req` is low in the cycle after the final write of a block.
- R8: With `cfg_yield`=1, a write that is not the final one and that sees `ext_bus_req`=1 is followed by a cycle with `bus_req` low. The remaining units resume after the grant returns.
- R9: With `cfg_yield`=0, `bus_req` stays high from acceptance to the end of the block, whatever `ext_bus_req` does.
- R10: `hi_pri_req`=1 blocks acceptance of a request in IDLE. While a block is active, `hi_pri_held` follows `hi_pri_req`.
- R11: `blocks_left` decrements at each block end. At the end of the block that brings it from 1 to 0, `chan_en` clears and `irq` is set.
- R12: `abort` during an active block returns to IDLE with `bus_req` low in the next cycle and clears `chan_en`, with no `irq` and no `blk_end`.
- R13: Read and write cycles happen only while `bus_gnt` is 1. The engine leaves WAITGNT only on grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_szcnt | input | 24 | [23:16] block size, [15:0] block count |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_word | input | 1 | 1 = word units, 0 = byte units |
| cfg_src_mode | input | 2 | Source step mode |
| cfg_dst_mode | input | 2 | Destination step mode |
| cfg_yield | input | 1 | Give the bus up between units on request |
| xfer_req | input | 1 | Transfer request |
| hi_pri_req | input | 1 | Higher-priority channel request pending |
| abort | input | 1 | Non-maskable stop |
| ext_bus_req | input | 1 | Another master wants the bus |
| bus_gnt | input | 1 | Bus grant |
| bus_rdata | input | DW | Read data |
| bus_req | output | 1 | Bus request |
| bus_rd | output | 1 | Read cycle |
| bus_wr | output | 1 | Write cycle |
| bus_addr | output | AW | Cycle address |
| bus_wdata | output | DW | Write data |
| bus_word | output | 1 | Unit size of the cycle |
| ack | output | 1 | Request accepted pulse |
| blk_end | output | 1 | Final unit write strobe |
| hi_pri_held | output | 1 | Higher-priority request being held off |
| chan_en | output | 1 | Channel enabled |
| blocks_left | output | 16 | Blocks remaining |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest situation to reach is a yield in the middle of a block. It needs yield enabled, another master's request present during a write that is not the final one, and a grant that returns later. The stimulus toggles `ext_bus_req` at random on most cycles while random blocks run with yield on or off. A grant model in the bench holds the grant once it is given. This covers both the yield and the no-yield path across many unit positions. Directed cases cover a 256-unit block, an abort in the middle of a block, and requests held off by a higher-priority request.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
    localparam int SZCNT_W = 24;
    localparam int SIZE_W  = 8;
    localparam int CNT_W   = SZCNT_W - SIZE_W;
    localparam int UNITS_W = SIZE_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAITGNT,
        ST_READ,
        ST_WRITE,
        ST_YIELD
    } dma_state_e;

    localparam logic [1:0] AM_INC = 2'b01;
    localparam logic [1:0] AM_DEC = 2'b10;
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr
    import dma_blk_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic [1:0]    mode,
    input  logic          word,
    input  logic          adv,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] step_mag;

    assign step_mag = word ? AW'(2) : AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (adv) begin
            unique case (mode)
                AM_INC:  addr <= addr + step_mag;
                AM_DEC:  addr <= addr - step_mag;
                default: addr <= addr;
            endcase
        end
    end

    // R4: step direction and magnitude per mode
    assert_step_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && mode == AM_INC && !word) |=> addr == $past(addr) + AW'(1));
    assert_step_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && mode == AM_DEC && word) |=> addr == $past(addr) - AW'(2));
    // R5: no restore unless a load happens
    assert_no_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(addr));
endmodule

// File: rtl/dma_blk_fsm.sv
module dma_blk_fsm
    import dma_blk_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int UW = UNITS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_cnt,
    input  logic [UW-1:0] size_units,
    input  logic          yield_en,
    input  logic          xfer_req,
    input  logic          hi_pri_req,
    input  logic          abort,
    input  logic          ext_bus_req,
    input  logic          bus_gnt,
    output logic          bus_req,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          blk_end,
    output logic          ack,
    output logic          hi_pri_held,
    output logic          chan_en,
    output logic [CW-1:0] blocks_left,
    output logic          irq,
    output logic          idle
);
    dma_state_e    state_q, state_d;
    logic          accept;
    logic [UW-1:0] units_q;
    logic          last_unit;
    logic          active;

    assign last_unit = (units_q == UW'(1));
    assign active    = (state_q != ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (chan_en && xfer_req && !hi_pri_req) begin
                    state_d = ST_WAITGNT;
                    accept  = 1'b1;
                end
            end
            ST_WAITGNT: begin
                if (abort)        state_d = ST_IDLE;
                else if (bus_gnt) state_d = ST_READ;
            end
            ST_READ: begin
                if (abort) state_d = ST_IDLE;
                else       state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (abort || last_unit)         state_d = ST_IDLE;
                else if (yield_en && ext_bus_req) state_d = ST_YIELD;
                else                            state_d = ST_READ;
            end
            ST_YIELD: begin
                if (abort)             state_d = ST_IDLE;
                else if (!ext_bus_req) state_d = ST_WAITGNT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req     = (state_q == ST_WAITGNT) || (state_q == ST_READ) || (state_q == ST_WRITE);
        bus_rd      = (state_q == ST_READ);
        bus_wr      = (state_q == ST_WRITE);
        blk_end     = (state_q == ST_WRITE) && last_unit && !abort;
        hi_pri_held = hi_pri_req && active;
        idle        = !active;
    end

    // unit, block, enable and interrupt bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            units_q     <= '0;
            blocks_left <= '0;
            chan_en     <= 1'b0;
            irq         <= 1'b0;
            ack         <= 1'b0;
        end else begin
            ack <= accept;
            if (accept)
                units_q <= size_units;
            else if (bus_wr && !abort)
                units_q <= units_q - UW'(1);

            if (load) begin
                blocks_left <= load_cnt;
                chan_en     <= 1'b1;
                irq         <= 1'b0;
            end else if (abort && active) begin
                chan_en <= 1'b0;
            end else if (blk_end) begin
                blocks_left <= blocks_left - CW'(1);
                if (blocks_left == CW'(1)) begin
                    chan_en <= 1'b0;
                    irq     <= 1'b1;
                end
            end
        end
    end

    assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    assert_ack_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (state_q == ST_WAITGNT || state_q == ST_IDLE));
    assert_end_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end |-> bus_wr);
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end |=> !bus_req);
    assert_yield_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !last_unit && yield_en && ext_bus_req && !abort) |=> !bus_req);
    assert_hold_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && hi_pri_req) |=> !ack);
    assert_irq_disables_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !chan_en);
    assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && active) |=> (!bus_req && !chan_en));
    assert_grant_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAITGNT && !bus_gnt && !abort) |=> state_q == ST_WAITGNT);
endmodule

// File: rtl/dma_blk_seq.sv
module dma_blk_seq
    import dma_blk_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_load,
    input  logic [SZCNT_W-1:0] cfg_szcnt,
    input  logic [AW-1:0]      cfg_src,
    input  logic [AW-1:0]      cfg_dst,
    input  logic               cfg_word,
    input  logic [1:0]         cfg_src_mode,
    input  logic [1:0]         cfg_dst_mode,
    input  logic               cfg_yield,
    input  logic               xfer_req,
    input  logic               hi_pri_req,
    input  logic               abort,
    input  logic               ext_bus_req,
    input  logic               bus_gnt,
    input  logic [DW-1:0]      bus_rdata,
    output logic               bus_req,
    output logic               bus_rd,
    output logic               bus_wr,
    output logic [AW-1:0]      bus_addr,
    output logic [DW-1:0]      bus_wdata,
    output logic               bus_word,
    output logic               ack,
    output logic               blk_end,
    output logic               hi_pri_held,
    output logic               chan_en,
    output logic [CNT_W-1:0]   blocks_left,
    output logic               irq
);
    logic [SIZE_W-1:0]  size_q;
    logic               word_q;
    logic               yield_q;
    logic [1:0]         smode_q;
    logic [1:0]         dmode_q;
    logic [DW-1:0]      data_q;
    logic               idle;
    logic               load_ok;
    logic [UNITS_W-1:0] size_units;
    logic [AW-1:0]      src_addr;
    logic [AW-1:0]      dst_addr;

    assign load_ok    = cfg_load && idle;
    assign size_units = (size_q == '0) ? UNITS_W'(1 << SIZE_W) : {1'b0, size_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q  <= '0;
            word_q  <= 1'b0;
            yield_q <= 1'b0;
            smode_q <= '0;
            dmode_q <= '0;
        end else if (load_ok) begin
            size_q  <= cfg_szcnt[SZCNT_W-1:CNT_W];
            word_q  <= cfg_word;
            yield_q <= cfg_yield;
            smode_q <= cfg_src_mode;
            dmode_q <= cfg_dst_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (bus_rd) data_q <= bus_rdata;
    end

    dma_blk_fsm #(.CW(CNT_W), .UW(UNITS_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load_ok),
        .load_cnt    (cfg_szcnt[CNT_W-1:0]),
        .size_units  (size_units),
        .yield_en    (yield_q),
        .xfer_req    (xfer_req),
        .hi_pri_req  (hi_pri_req),
        .abort       (abort),
        .ext_bus_req (ext_bus_req),
        .bus_gnt     (bus_gnt),
        .bus_req     (bus_req),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .blk_end     (blk_end),
        .ack         (ack),
        .hi_pri_held (hi_pri_held),
        .chan_en     (chan_en),
        .blocks_left (blocks_left),
        .irq         (irq),
        .idle        (idle)
    );

    dma_addr_ctr #(.AW(AW)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .load_val (cfg_src),
        .mode     (smode_q),
        .word     (word_q),
        .adv      (bus_rd),
        .addr     (src_addr)
    );

    dma_addr_ctr #(.AW(AW)) u_dst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .load_val (cfg_dst),
        .mode     (dmode_q),
        .word     (word_q),
        .adv      (bus_wr),
        .addr     (dst_addr)
    );

    assign bus_addr  = bus_rd ? src_addr : dst_addr;
    assign bus_wdata = data_q;
    assign bus_word  = word_q;

    // R1: configuration is ignored while a block runs
    assert_load_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && !idle) |=> $stable(size_q));
    // R13: bus cycles only with grant
    assert_cycles_granted_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_gnt) |-> 1'b0);
endmodule

// File: tb/tb_dma_blk_seq.sv
module tb_dma_blk_seq;
    localparam int AW = 24;
    localparam int DW = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [23:0]   cfg_szcnt = '0;
    logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
    logic          cfg_word = 1'b0, cfg_yield = 1'b0;
    logic [1:0]    cfg_src_mode = '0, cfg_dst_mode = '0;
    logic          xfer_req = 1'b0, hi_pri_req = 1'b0, abort = 1'b0, ext_req = 1'b0;
    logic          gnt;
    logic [DW-1:0] bus_rdata;
    logic          bus_req, bus_rd, bus_wr, bus_word, ack, blk_end, hi_pri_held, chan_en, irq;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [15:0]   blocks_left;

    dma_blk_seq #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_szcnt(cfg_szcnt),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_word(cfg_word),
        .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode), .cfg_yield(cfg_yield),
        .xfer_req(xfer_req), .hi_pri_req(hi_pri_req), .abort(abort),
        .ext_bus_req(ext_req), .bus_gnt(gnt), .bus_rdata(bus_rdata),
        .bus_req(bus_req), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_word(bus_word), .ack(ack), .blk_end(blk_end),
        .hi_pri_held(hi_pri_held), .chan_en(chan_en), .blocks_left(blocks_left), .irq(irq)
    );

    function automatic logic [DW-1:0] fdata(input logic [AW-1:0] a);
        return a[15:0] ^ 16'h5A3C ^ {a[23:16], 8'h00};
    endfunction

    function automatic logic [AW-1:0] stepv(input logic [1:0] m, input logic w);
        logic [AW-1:0] mag;
        mag = w ? AW'(2) : AW'(1);
        if (m == 2'b01) return mag;
        if (m == 2'b10) return AW'(0) - mag;
        return AW'(0);
    endfunction

    assign bus_rdata = fdata(bus_addr);

    // bus arbiter model: grant held once given
    always @(posedge clk) begin
        if (!rst_n) gnt <= 1'b0;
        else        gnt <= bus_req && (!ext_req || gnt);
    end

    int checks = 0, fails = 0, cyc = 0;
    bit ext_on = 0, mon_on = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        ext_req = ext_on ? ($urandom_range(0, 3) == 0) : 1'b0;
    end

    // reference monitor
    logic [AW-1:0] e_src, e_dst, last_rd;
    int  e_size = 1, units = 0, acks = 0, blocks_done = 0;
    bit  in_blk = 0, m_yield = 0, m_word = 0;
    logic [1:0] m_sm = '0, m_dm = '0;
    bit  prev_end = 0, prev_mid = 0, prev_ext = 0, prev_abort = 0;

    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (bus_rd || bus_wr) chk(gnt, "R13 grant", gnt, 1);
            if (prev_end)   chk(!bus_req, "R7 release", bus_req, 0);
            if (prev_abort) chk(!bus_req, "R12 abort release", bus_req, 0);
            if (prev_mid && m_yield && prev_ext) chk(!bus_req, "R8 yield", bus_req, 0);
            if (ack) begin
                acks++;
                in_blk = 1;
                units = 0;
            end
            if (in_blk && !m_yield) chk(bus_req, "R9 no yield", bus_req, 1);
            if (bus_rd) begin
                chk(bus_addr == e_src, "R4 R5 src addr", bus_addr, e_src);
                last_rd = bus_addr;
                e_src = e_src + stepv(m_sm, m_word);
            end
            if (bus_wr) begin
                chk(bus_addr == e_dst, "R4 R5 dst addr", bus_addr, e_dst);
                chk(bus_wdata == fdata(last_rd), "R3 data", bus_wdata, fdata(last_rd));
                chk(blk_end == (units == e_size - 1), "R6 blk_end", blk_end, (units == e_size - 1));
                e_dst = e_dst + stepv(m_dm, m_word);
                units++;
            end
            prev_end   = blk_end;
            prev_mid   = bus_wr && !blk_end;
            prev_ext   = ext_req;
            prev_abort = abort && in_blk;
            if (blk_end) begin
                in_blk = 0;
                blocks_done++;
            end
            if (abort) in_blk = 0;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            summary();
            $finish;
        end
    end

    task automatic configure(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [7:0] sz,
                             input logic [15:0] cnt, input logic w, input logic [1:0] sm,
                             input logic [1:0] dm, input logic y);
        @(posedge clk); #1;
        cfg_src = s; cfg_dst = d; cfg_szcnt = {sz, cnt}; cfg_word = w;
        cfg_src_mode = sm; cfg_dst_mode = dm; cfg_yield = y; cfg_load = 1'b1;
        @(posedge clk); #1;
        cfg_load = 1'b0;
        e_src = s; e_dst = d; e_size = (sz == 0) ? 256 : int'(sz);
        m_sm = sm; m_dm = dm; m_word = w; m_yield = y;
        chk(chan_en == 1'b1, "R1 enable", chan_en, 1);
        chk(irq == 1'b0, "R1 irq clear", irq, 0);
        chk(blocks_left == cnt, "R1 count", blocks_left, cnt);
    endtask

    task automatic start_block();
        int a0;
        a0 = acks;
        xfer_req = 1'b1;
        while (acks == a0) @(posedge clk);
        #1;
        xfer_req = 1'b0;
    endtask

    task automatic finish_block(input int b0, input int a0, input logic [15:0] exp_left);
        while (blocks_done == b0) @(posedge clk);
        #1;
        chk(blocks_left == exp_left, "R11 count dec", blocks_left, exp_left);
        chk(acks == a0 + 1, "R2 one ack per block", acks, a0 + 1);
    endtask

    task automatic run_block(input logic [15:0] exp_left);
        int b0, a0;
        b0 = blocks_done;
        a0 = acks;
        start_block();
        finish_block(b0, a0, exp_left);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1;
        chk(bus_req == 0 && ack == 0, "R2 reset idle", {bus_req, ack}, 0);
        chk(chan_en == 0 && irq == 0, "R11 reset", {chan_en, irq}, 0);
        rst_n = 1'b1;
        mon_on = 1;

        // directed: two byte blocks, inc/inc, addresses continue (R5)
        configure(24'h000100, 24'h008000, 8'd4, 16'd2, 1'b0, 2'b01, 2'b01, 1'b0);
        run_block(16'd1);
        chk(chan_en == 1 && irq == 0, "R11 not done", {chan_en, irq}, 2'b10);
        run_block(16'd0);
        chk(irq == 1 && chan_en == 0, "R11 irq", {irq, chan_en}, 2'b10);
        xfer_req = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        xfer_req = 1'b0;
        chk(bus_req == 0, "R2 disabled no accept", bus_req, 0);

        // directed: 256-unit word block, inc/dec
        configure(24'h010000, 24'h02FFFE, 8'd0, 16'd1, 1'b1, 2'b01, 2'b10, 1'b0);
        run_block(16'd0);
        chk(units == 256, "R3 size zero is 256", units, 256);
        chk(irq == 1, "R11 irq big", irq, 1);

        // directed: hold-off by higher priority, load ignored while busy
        configure(24'h000400, 24'h000500, 8'd6, 16'd1, 1'b0, 2'b10, 2'b00, 1'b0);
        begin
            int a0, b0;
            a0 = acks;
            b0 = blocks_done;
            hi_pri_req = 1'b1;
            xfer_req = 1'b1;
            repeat (6) @(posedge clk);
            #1;
            chk(acks == a0 && bus_req == 0, "R10 held off", acks, a0);
            hi_pri_req = 1'b0;
            start_block();
            hi_pri_req = 1'b1;
            cfg_src = 24'hABCDEF;
            cfg_szcnt = 24'h020009;
            cfg_load = 1'b1;
            @(negedge clk);
            chk(hi_pri_held == 1, "R10 held flag", hi_pri_held, 1);
            @(posedge clk); #1;
            cfg_load = 1'b0;
            hi_pri_req = 1'b0;
            chk(blocks_left == 16'd1, "R1 load ignored busy", blocks_left, 1);
            finish_block(b0, a0, 16'd0);
            hi_pri_req = 1'b1;
            @(negedge clk);
            chk(hi_pri_held == 0, "R10 idle no held", hi_pri_held, 0);
            @(posedge clk); #1;
            hi_pri_req = 1'b0;
        end

        // directed: abort mid-block
        configure(24'h000800, 24'h000900, 8'd8, 16'd2, 1'b1, 2'b01, 2'b01, 1'b0);
        begin
            int b0;
            b0 = blocks_done;
            start_block();
            repeat (5) @(posedge clk);
            #1;
            abort = 1'b1;
            @(posedge clk); #1;
            abort = 1'b0;
            chk(bus_req == 0, "R12 stopped", bus_req, 0);
            chk(chan_en == 0 && irq == 0, "R12 disabled no irq", {chan_en, irq}, 0);
            chk(blocks_done == b0, "R12 no blk_end", blocks_done, b0);
            chk(blocks_left == 16'd2, "R12 count kept", blocks_left, 2);
        end

        // random: yield on/off, other master toggling
        ext_on = 1;
        for (int n = 0; n < 14; n++) begin
            logic [7:0]  sz;
            logic [15:0] cnt;
            sz  = 8'($urandom_range(1, 10));
            cnt = 16'($urandom_range(1, 3));
            configure(AW'($urandom), AW'($urandom), sz, cnt, 1'($urandom),
                      2'($urandom), 2'($urandom), 1'($urandom));
            for (int k = int'(cnt) - 1; k >= 0; k--) run_block(16'(k));
            chk(irq == 1 && chan_en == 0, "R11 random done", {irq, chan_en}, 2'b10);
        end
        ext_on = 0;
        repeat (3) @(posedge clk);

        summary();
        $finish;
    end
endmodule